// File: doc/BRIEF.md
# RGMII transmit nibble adapter

This block turns a byte-wide MAC transmit stream into the four-bit reduced gigabit media-independent transmit pins. It drives the forwarded transmit clock, the four data lines and the single control line. It runs from a 125 MHz reference. The link speed is picked at run time. At gigabit the block moves one byte per reference cycle as two nibbles, one per clock edge. At 100 and 10 Mbps it sends each nibble for a whole transmit clock period. Those slower transmit clocks come from the reference through enable-based division.

The MAC offers a byte, an enable and an error flag. The block takes the byte on each rising reference edge at which `byte_ready` is high. At gigabit `byte_ready` stays high. At the slower speeds it pulses once every two transmit clock periods. A byte taken at edge k reaches the pins in the cycle that follows edge k+1. The double data rate outputs are modelled as two registered phase values. The reference clock level selects between them, so the high half of the reference shows the rising-edge phase and the low half shows the falling-edge phase.

Top module: `rgmii_tx_adapter`

## Requirements
- R1: While reset is held, the transmit clock, control line and data pins are all low, and the active speed is gigabit, so `byte_ready` is high.
- R2: At gigabit (`speed_sel` 2'b10 or 2'b11), `byte_ready` is high on every cycle. The low nibble of each byte is driven in the high half of the reference cycle and the high nibble in the low half.
- R3: At gigabit the forwarded clock follows the reference clock: it is high in the first half of each reference cycle and low in the second.
- R4: At 100 Mbps (`speed_sel` 2'b01), the forwarded clock period is five reference cycles, high for the first five half-cycles.
- R5: At 10 Mbps (`speed_sel` 2'b00), the forwarded clock period is fifty reference cycles, high for the first twenty-five.
- R6: At 10 and 100 Mbps, the low nibble of a byte is held for one whole forwarded clock period and the high nibble for the next. The data pins change only at a rising forwarded clock edge.
- R7: At 10 and 100 Mbps, `byte_ready` is high for one reference cycle in each pair of forwarded clock periods, so the gap is 10 cycles at 100 Mbps and 100 cycles at 10 Mbps.
- R8: While the forwarded clock is high, the control line carries the byte's enable. While it is low, the control line carries enable XOR error.
- R9: A byte taken with enable and error both low keeps the control line low in both halves of every period that carries it.
- R10: A new `speed_sel` value takes effect only at an edge where a byte is taken with enable low. A change made during a frame leaves the rest of that frame at the old speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_sel | input | 2 | Requested speed: 00 = 10 Mbps, 01 = 100 Mbps, 1x = gigabit |
| tx_data | input | 8 | Byte from the MAC |
| tx_en | input | 1 | Byte belongs to a frame |
| tx_er | input | 1 | Byte carries a transmit error |
| byte_ready | output | 1 | The byte on the inputs is taken at the next rising edge |
| rgmii_txc | output | 1 | Forwarded transmit clock |
| rgmii_txd | output | 4 | Transmit data nibble |
| rgmii_tx_ctl | output | 1 | Transmit control line |

## Verification
A speed change and the transfer of a frame byte can meet in the same cycle. The bench provokes this by moving `speed_sel` while a gigabit frame is still being sent, and then letting the frame run on. The byte-ready gap must stay at one cycle, and the forwarded clock period must not change, until the first idle byte is taken. Only after that may the period become five reference cycles. An error flag set in the middle of a frame shares the control line with the enable, and the falling phase of the control line is checked to show it.

// File: rtl/rgmii_tx_pkg.sv
package rgmii_tx_pkg;

  typedef enum logic [1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10
  } speed_e;

  // Map the raw selector to a speed; both upper codes mean gigabit.
  function automatic speed_e decode_speed(input logic [1:0] sel);
    return sel[1] ? SPD_1000 : speed_e'(sel);
  endfunction

  // Reference cycles per forwarded clock period.
  function automatic int unsigned ref_div(input speed_e s,
                                          input int unsigned d100,
                                          input int unsigned d10);
    case (s)
      SPD_100: return d100;
      SPD_10:  return d10;
      default: return 1;
    endcase
  endfunction

  // A half-cycle slot is in the high part of the period when it falls
  // inside the first div half-cycles (period = 2*div half-cycles).
  function automatic logic half_high(input int unsigned half,
                                     input int unsigned div);
    return half < div;
  endfunction

  // Reference cycles between byte handshakes.
  function automatic int unsigned ready_gap(input speed_e s,
                                            input int unsigned d100,
                                            input int unsigned d10);
    return (s == SPD_1000) ? 1 : 2 * ref_div(s, d100, d10);
  endfunction

endpackage

// File: rtl/rgmii_tx_slot.sv
module rgmii_tx_slot
  import rgmii_tx_pkg::*;
#(
  parameter int unsigned DIV100 = 5,
  parameter int unsigned DIV10  = 50,
  parameter int unsigned CW     = $clog2(DIV10)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    speed_sel,
  input  logic          tx_en,
  output speed_e        spd_q,
  output logic [CW-1:0] slot_cnt,
  output logic          nib_sel,
  output logic          byte_ready,
  output logic          speed_commit
);

  int unsigned div;
  logic        last_slot;

  always_comb begin
    div          = ref_div(spd_q, DIV100, DIV10);
    last_slot    = (32'(slot_cnt) == div - 1);
    byte_ready   = (spd_q == SPD_1000) || (last_slot && nib_sel);
    speed_commit = byte_ready && !tx_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spd_q    <= SPD_1000;
      slot_cnt <= '0;
      nib_sel  <= 1'b0;
    end else if (byte_ready) begin
      slot_cnt <= '0;
      nib_sel  <= 1'b0;
      if (speed_commit) spd_q <= decode_speed(speed_sel);
    end else if (last_slot) begin
      slot_cnt <= '0;
      nib_sel  <= 1'b1;
    end else begin
      slot_cnt <= slot_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rgmii_tx_phase.sv
module rgmii_tx_phase
  import rgmii_tx_pkg::*;
#(
  parameter int unsigned DIV100 = 5,
  parameter int unsigned DIV10  = 50,
  parameter int unsigned CW     = $clog2(DIV10),
  parameter int unsigned NW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  speed_e        spd,
  input  logic [CW-1:0] slot_cnt,
  input  logic          nib_sel,
  input  logic [2*NW-1:0] hold_data,
  input  logic          hold_en,
  input  logic          hold_er,
  output logic          txc_r,
  output logic          txc_f,
  output logic          ctl_r,
  output logic          ctl_f,
  output logic [NW-1:0] d_r,
  output logic [NW-1:0] d_f
);

  int unsigned   div;
  logic          n_txc_r, n_txc_f;
  logic [NW-1:0] n_d_r, n_d_f, sdr_nib;

  always_comb begin
    div     = ref_div(spd, DIV100, DIV10);
    sdr_nib = nib_sel ? hold_data[2*NW-1:NW] : hold_data[NW-1:0];
    if (spd == SPD_1000) begin
      n_txc_r = 1'b1;
      n_txc_f = 1'b0;
      n_d_r   = hold_data[NW-1:0];
      n_d_f   = hold_data[2*NW-1:NW];
    end else begin
      n_txc_r = half_high(2 * 32'(slot_cnt), div);
      n_txc_f = half_high(2 * 32'(slot_cnt) + 1, div);
      n_d_r   = sdr_nib;
      n_d_f   = sdr_nib;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txc_r <= 1'b0;
      txc_f <= 1'b0;
      ctl_r <= 1'b0;
      ctl_f <= 1'b0;
      d_r   <= '0;
      d_f   <= '0;
    end else begin
      txc_r <= n_txc_r;
      txc_f <= n_txc_f;
      ctl_r <= n_txc_r ? hold_en : (hold_en ^ hold_er);
      ctl_f <= n_txc_f ? hold_en : (hold_en ^ hold_er);
      d_r   <= n_d_r;
      d_f   <= n_d_f;
    end
  end

endmodule

// File: rtl/rgmii_tx_ddr_out.sv
module rgmii_tx_ddr_out #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic [W-1:0] rise_bits,
  input  logic [W-1:0] fall_bits,
  output logic [W-1:0] pin_bits
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign pin_bits[i] = clk ? rise_bits[i] : fall_bits[i];
  end

endmodule

// File: rtl/rgmii_tx_adapter.sv
module rgmii_tx_adapter
  import rgmii_tx_pkg::*;
#(
  parameter int unsigned DIV100 = 5,
  parameter int unsigned DIV10  = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] speed_sel,
  input  logic [7:0] tx_data,
  input  logic       tx_en,
  input  logic       tx_er,
  output logic       byte_ready,
  output logic       rgmii_txc,
  output logic [3:0] rgmii_txd,
  output logic       rgmii_tx_ctl
);

  localparam int unsigned CW = $clog2(DIV10);
  localparam int unsigned NW = 4;
  localparam int unsigned PW = NW + 2;

  speed_e        spd_q;
  logic [CW-1:0] slot_cnt;
  logic          nib_sel;
  logic          speed_commit;
  logic [7:0]    hold_data;
  logic          hold_en, hold_er;
  logic          txc_r, txc_f, ctl_r, ctl_f;
  logic [NW-1:0] d_r, d_f;

  rgmii_tx_slot #(.DIV100(DIV100), .DIV10(DIV10), .CW(CW)) u_slot (
    .clk          (clk),
    .rst_n        (rst_n),
    .speed_sel    (speed_sel),
    .tx_en        (tx_en),
    .spd_q        (spd_q),
    .slot_cnt     (slot_cnt),
    .nib_sel      (nib_sel),
    .byte_ready   (byte_ready),
    .speed_commit (speed_commit)
  );

  // Byte holding register, loaded on each handshake.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_data <= '0;
      hold_en   <= 1'b0;
      hold_er   <= 1'b0;
    end else if (byte_ready) begin
      hold_data <= tx_data;
      hold_en   <= tx_en;
      hold_er   <= tx_er;
    end
  end

  rgmii_tx_phase #(.DIV100(DIV100), .DIV10(DIV10), .CW(CW), .NW(NW)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .spd       (spd_q),
    .slot_cnt  (slot_cnt),
    .nib_sel   (nib_sel),
    .hold_data (hold_data),
    .hold_en   (hold_en),
    .hold_er   (hold_er),
    .txc_r     (txc_r),
    .txc_f     (txc_f),
    .ctl_r     (ctl_r),
    .ctl_f     (ctl_f),
    .d_r       (d_r),
    .d_f       (d_f)
  );

  rgmii_tx_ddr_out #(.W(PW)) u_ddr (
    .clk       (clk),
    .rise_bits ({txc_r, ctl_r, d_r}),
    .fall_bits ({txc_f, ctl_f, d_f}),
    .pin_bits  ({rgmii_txc, rgmii_tx_ctl, rgmii_txd})
  );

endmodule

// File: rtl/rgmii_tx_adapter_chk.sv
module rgmii_tx_adapter_chk
  import rgmii_tx_pkg::*;
#(
  parameter int unsigned DIV100 = 5,
  parameter int unsigned DIV10  = 50
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       byte_ready,
  input logic       speed_commit,
  input speed_e     spd_q,
  input logic       txc_r,
  input logic       txc_f,
  input logic       ctl_r,
  input logic       ctl_f,
  input logic [3:0] d_r,
  input logic       hold_en,
  input logic       hold_er
);

  logic [1:0]  arm_cnt;
  logic        armed1, armed2;
  int unsigned gap;
  logic        gap_valid;
  speed_e      spd_prev;

  assign armed1 = arm_cnt != 2'd0;
  assign armed2 = arm_cnt == 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_cnt   <= 2'd0;
      gap       <= 0;
      gap_valid <= 1'b0;
      spd_prev  <= SPD_1000;
    end else begin
      if (arm_cnt != 2'd2) arm_cnt <= arm_cnt + 2'd1;
      spd_prev <= spd_q;
      gap      <= byte_ready ? 1 : gap + 1;
      if (spd_q != spd_prev)  gap_valid <= 1'b0;
      else if (byte_ready)    gap_valid <= 1'b1;
    end
  end

  // R7 / R2: handshake spacing at a steady speed
  a_r7_ready_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_valid && byte_ready && spd_q == spd_prev)
      |-> gap == ready_gap(spd_q, DIV100, DIV10));

  // R3: gigabit forwarded clock high in first half, low in second
  a_r3_gig_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (armed1 && $past(spd_q) == SPD_1000) |-> (txc_r && !txc_f));

  // R10: the speed only moves on an idle handshake
  a_r10_commit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (armed1 && spd_q != $past(spd_q)) |-> $past(byte_ready && !tx_en && speed_commit));

  // R9: an idle byte keeps the control line low
  a_r9_idle_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    (armed1 && !$past(hold_en) && !$past(hold_er)) |-> (!ctl_r && !ctl_f));

  // R6: slow-speed data changes only where the forwarded clock rises
  a_r6_sdr_data_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (armed2 && $past(spd_q) != SPD_1000 && $past(spd_q, 2) != SPD_1000 && d_r != $past(d_r))
      |-> (txc_r && !$past(txc_f)));

endmodule

bind rgmii_tx_adapter rgmii_tx_adapter_chk #(.DIV100(DIV100), .DIV10(DIV10)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tx_en        (tx_en),
  .byte_ready   (byte_ready),
  .speed_commit (speed_commit),
  .spd_q        (spd_q),
  .txc_r        (txc_r),
  .txc_f        (txc_f),
  .ctl_r        (ctl_r),
  .ctl_f        (ctl_f),
  .d_r          (d_r),
  .hold_en      (hold_en),
  .hold_er      (hold_er)
);

// File: tb/tb_rgmii_tx_adapter.sv
module tb_rgmii_tx_adapter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] speed_sel = 2'b10;
  logic [7:0] tx_data = 8'h00;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic       byte_ready;
  logic       rgmii_txc;
  logic [3:0] rgmii_txd;
  logic       rgmii_tx_ctl;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_gig = 0, n_100 = 0, n_10 = 0;
  logic [8:0] exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rgmii_tx_adapter dut (
    .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel),
    .tx_data(tx_data), .tx_en(tx_en), .tx_er(tx_er),
    .byte_ready(byte_ready), .rgmii_txc(rgmii_txc),
    .rgmii_txd(rgmii_txd), .rgmii_tx_ctl(rgmii_tx_ctl)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: offers n bytes at handshakes; frame bytes go to the scoreboard.
  task automatic send(input logic en, input int n, input int err_idx,
                      input logic [7:0] base, input int gap_exp, input string req);
    int last = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!byte_ready) @(negedge clk);
      if (gap_exp > 0 && last >= 0)
        chk(cyc - last == gap_exp, req, "handshake gap", cyc - last, gap_exp);
      last = cyc;
      tx_data = en ? base + 8'(i * 37) : 8'h00;
      tx_en   = en;
      tx_er   = en && (i == err_idx);
      if (en) exp_q.push_back({tx_er, tx_data});
    end
  endtask

  // Monitor state
  logic       prev_c = 1'b0;
  int         high_cnt = 0;
  logic [3:0] nib_a;
  logic       en_a;
  logic       have_lo = 1'b0;
  logic [3:0] lo_nib;
  logic       lo_er;

  task automatic score(input logic [7:0] b, input logic er, input string req);
    logic [8:0] e;
    if (exp_q.size() == 0) begin
      chk(1'b0, req, "unexpected byte", {23'd0, er, b}, 0);
    end else begin
      e = exp_q.pop_front();
      chk({er, b} == e, req, "byte", {23'd0, er, b}, {23'd0, e});
    end
  endtask

  task automatic period_end(input logic [3:0] nib_b, input logic ctl_b);
    logic er;
    er = en_a ^ ctl_b;
    if (high_cnt == 1) begin
      n_gig++;
      if (en_a) score({nib_b, nib_a}, er, "R2 R8");
      else chk(!ctl_b, "R9", "idle ctl low half", ctl_b, 0);
    end else begin
      chk(high_cnt == 5 || high_cnt == 50, "R4 R5", "txc high half-cycles", high_cnt, 5);
      if (high_cnt == 5) n_100++;
      if (high_cnt == 50) n_10++;
      chk(nib_a == nib_b, "R6", "nibble held through period", nib_b, nib_a);
      if (en_a) begin
        if (!have_lo) begin
          lo_nib = nib_a; lo_er = er; have_lo = 1'b1;
        end else begin
          score({nib_a, lo_nib}, er | lo_er, "R6 R8");
          have_lo = 1'b0;
        end
      end else begin
        have_lo = 1'b0;
        chk(!ctl_b, "R9", "idle ctl low half", ctl_b, 0);
      end
    end
  endtask

  task automatic sample(input logic c, input logic [3:0] d, input logic ctl);
    if (c && !prev_c) begin
      nib_a = d; en_a = ctl; high_cnt = 1;
    end else if (c) begin
      high_cnt++;
    end else if (prev_c) begin
      period_end(d, ctl);
    end
    prev_c = c;
  endtask

  initial begin
    forever begin
      @(posedge clk); #2;
      sample(rgmii_txc, rgmii_txd, rgmii_tx_ctl);
      @(negedge clk); #2;
      sample(rgmii_txc, rgmii_txd, rgmii_tx_ctl);
    end
  end

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "ALL", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #2;
    // R1: reset state, both halves
    chk(rgmii_txc == 1'b0 && rgmii_tx_ctl == 1'b0 && rgmii_txd == 4'h0, "R1",
        "pins in reset (high half)", {rgmii_txc, rgmii_tx_ctl, rgmii_txd}, 0);
    chk(byte_ready == 1'b1, "R1", "gigabit handshake in reset", byte_ready, 1);
    @(negedge clk); #2;
    chk(rgmii_txc == 1'b0 && rgmii_tx_ctl == 1'b0 && rgmii_txd == 4'h0, "R1",
        "pins in reset (low half)", {rgmii_txc, rgmii_tx_ctl, rgmii_txd}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 R3 R8: gigabit frame with an error byte
    send(1'b0, 3, -1, 8'h00, 1, "R2");
    send(1'b1, 16, 5, 8'h1b, 1, "R2");
    send(1'b0, 4, -1, 8'h00, 1, "R2");

    // R10: speed request during a frame must wait for the frame end
    send(1'b1, 3, -1, 8'h40, 1, "R10");
    speed_sel = 2'b01;
    send(1'b1, 8, -1, 8'h77, 1, "R10");
    send(1'b0, 1, -1, 8'h00, 0, "R10");
    send(1'b0, 2, -1, 8'h00, 10, "R7");

    // R4 R6 R7 R8: 100 Mbps frame with an error byte
    send(1'b1, 6, 3, 8'hc5, 10, "R7");
    send(1'b0, 2, -1, 8'h00, 10, "R7");

    // R5 R6 R7: 10 Mbps frame
    speed_sel = 2'b00;
    send(1'b0, 2, -1, 8'h00, 0, "R10");
    send(1'b1, 3, -1, 8'h9e, 100, "R7");
    send(1'b0, 2, -1, 8'h00, 100, "R7");

    // R2: code 2'b11 also selects gigabit
    speed_sel = 2'b11;
    send(1'b0, 2, -1, 8'h00, 0, "R10");
    send(1'b1, 4, 0, 8'h3c, 1, "R2");
    send(1'b0, 300, -1, 8'h00, 1, "R2");

    chk(exp_q.size() == 0, "R2 R6", "scoreboard drained", exp_q.size(), 0);
    chk(n_gig > 0, "R3", "gigabit periods seen", n_gig, 1);
    chk(n_100 > 0, "R4", "100 Mbps periods seen", n_100, 1);
    chk(n_10 > 0, "R5", "10 Mbps periods seen", n_10, 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule